// File: doc/BRIEF.md
# Serial Control and Status Port

This block is a synchronous serial slave framed by an active-low select. While select is low it takes in a control word on its data input and, in the same frame, sends out a status word. Both words are 16 bits and travel least significant bit first. Input bits are taken on the falling serial-clock edge. Output bits move on the rising edge.

When select rises after a complete frame, the received word goes to the output-stage control logic as a parallel word, together with a one-cycle apply strobe. The status word comes in parallel from that same logic and is frozen when select falls. Its bit 0 is on the data output right away, so a host can read that one flag and then drop the frame without changing anything.

Bits that arrive after the sixteenth are passed on to the data output. This allows several devices to be chained on one data line. All three serial inputs pass through two-flop synchronisers. Their edges are detected in a system clock that runs at least eight times faster than the serial clock.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset the control word is 16'h2000 (only bit 13 set), the apply strobe is low, and the data output is disabled and driven low.
- R2: The data-output enable `sdo_oe` is high only while select is low. While it is low, `sdo` is 0.
- R3: Right after select falls, and before any serial-clock edge, `sdo` carries bit 0 of the status word.
- R4: The first rising serial-clock edge of a frame leaves `sdo` unchanged. Each later rising edge moves `sdo` to the next bit. After rising edge k+1, `sdo` shows bit k.
- R5: A frame with exactly 16 falling edges loads the control word with the bits taken on those edges, the first bit taken going to bit 0. The load happens when select rises and raises `ctrl_apply` for exactly one system cycle.
- R6: A frame whose count of falling edges is zero or not a multiple of 16 leaves the control word unchanged and gives no apply strobe.
- R7: In a frame of 32 falling edges, `sdo` sends input bits 0 to 15 of the frame after the 16 status bits. The control word takes the last 16 bits received.
- R8: The status word is sampled when select falls. A change of `stat_word` during the frame does not change the bits sent.
- R9: Serial-clock and data-input activity while select is high has no effect. The output stays disabled, the control word is unchanged, and no apply strobe occurs.
- R10: The control word changes only in a cycle where `ctrl_apply` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| stat_word | input | 16 | Parallel status word from the output-stage logic |
| sdo | output | 1 | Serial data out (0 when disabled) |
| sdo_oe | output | 1 | Enable for the external tristate buffer on the data output |
| ctrl_word | output | 16 | Last committed control word |
| ctrl_apply | output | 1 | One-cycle strobe when `ctrl_word` is loaded |

## Verification
The main function is driven with frames of 16 falling edges carrying different words and status values. These show whether bits end up in the right order and whether the output moves on the correct edge. Frames of 0, 5 and 17 edges separate the completed-word test from a simple "select rose" test. A 32-edge frame separates true pass-through from a wrap-around of the status bits. A status change inside a frame, and clock activity while deselected, show whether the capture point and the select gating are correct.

// File: rtl/ser_ctl_port.sv
module ser_ctl_port #(
  parameter int W = 16,
  parameter logic [W-1:0] CTRL_RST = 16'h2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         sdi,
  input  logic [W-1:0] stat_word,
  output logic         sdo,
  output logic         sdo_oe,
  output logic [W-1:0] ctrl_word,
  output logic         ctrl_apply
);
  localparam int CW = $clog2(W);

  logic [2:0]    cs_p, sck_p;
  logic [1:0]    sdi_p;
  logic          active, seen, wrapped, din_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      sdi_p <= '0;
    end else begin
      cs_p  <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sck};
      sdi_p <= {sdi_p[0], sdi};
    end

  wire cs_fall  = cs_p[2] & ~cs_p[1];
  wire cs_rise  = ~cs_p[2] & cs_p[1];
  wire sck_fall = active & sck_p[2] & ~sck_p[1];
  wire sck_rise = active & ~sck_p[2] & sck_p[1];
  wire commit   = active & cs_rise & wrapped & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active  <= 1'b0;
      seen    <= 1'b0;
      wrapped <= 1'b0;
      cnt     <= '0;
      din_q   <= 1'b0;
      sr      <= '0;
    end else if (cs_fall) begin
      active  <= 1'b1;
      seen    <= 1'b0;
      wrapped <= 1'b0;
      cnt     <= '0;
      sr      <= stat_word;
    end else if (active) begin
      if (cs_rise) begin
        active <= 1'b0;
      end else begin
        if (sck_fall) begin
          din_q <= sdi_p[1];
          seen  <= 1'b1;
          if (cnt == CW'(W - 1)) begin
            cnt     <= '0;
            wrapped <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (sck_rise && seen)
          sr <= {din_q, sr[W-1:1]};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_word  <= CTRL_RST;
      ctrl_apply <= 1'b0;
    end else begin
      ctrl_apply <= commit;
      if (commit)
        ctrl_word <= {din_q, sr[W-1:1]};
    end

  assign sdo    = active & sr[0];
  assign sdo_oe = active;
endmodule

module ser_ctl_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         sck,
  input logic         sdi,
  input logic [W-1:0] stat_word,
  input logic         sdo,
  input logic         sdo_oe,
  input logic [W-1:0] ctrl_word,
  input logic         ctrl_apply
);
  // R5
  apply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_apply |=> !ctrl_apply);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word != $past(ctrl_word)) |-> ctrl_apply);

  // R6
  apply_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_apply |-> !sdo_oe);

  // R9
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);
endmodule

bind ser_ctl_port ser_ctl_port_chk #(.W(W)) u_chk (.*);

// File: tb/ser_ctl_port_bench.sv
module ser_ctl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0;
  logic [15:0] stat_word = '0;
  logic sdo, sdo_oe, ctrl_apply;
  logic [15:0] ctrl_word;
  int checks = 0, errors = 0, apply_cnt = 0;
  logic [15:0] exp_ctrl = 16'h2000;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_ctl_port u_ser_ctl_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .stat_word(stat_word), .sdo(sdo), .sdo_oe(sdo_oe),
    .ctrl_word(ctrl_word), .ctrl_apply(ctrl_apply));

  always @(posedge clk) if (ctrl_apply) apply_cnt++;

  // {edges, status, data-in}
  localparam logic [55:0] VEC [7] = '{
    {8'd16, 16'h1234, 32'h0000_A5C3},
    {8'd16, 16'hFFFF, 32'h0000_0001},
    {8'd0,  16'h0001, 32'h0000_FFFF},
    {8'd5,  16'h8000, 32'h0000_001F},
    {8'd32, 16'h0F0F, 32'hDEAD_BEEF},
    {8'd17, 16'hAAAA, 32'h0001_5555},
    {8'd16, 16'h0000, 32'h0000_5A5A}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] st, input logic [31:0] din, input int n, input bit flip);
    int a0;
    bit commit;
    a0 = apply_cnt;
    stat_word = st;
    cs_n = 0;
    wait_n(H);
    chk("R2 enable on select", sdo_oe, 1);
    chk("R3 status bit0", sdo, st[0]);
    if (flip) stat_word = ~st;
    for (int i = 0; i < n; i++) begin
      sck = 1;
      sdi = din[i];
      wait_n(H);
      if (i < 16) chk("R4 R8 status bit", sdo, st[i]);
      else        chk("R7 pass-through bit", sdo, din[i-16]);
      sck = 0;
      wait_n(H);
    end
    cs_n = 1;
    wait_n(H);
    commit = (n > 0) && (n % 16 == 0);
    if (commit) exp_ctrl = 16'(din >> (n - 16));
    chk(commit ? "R5 control word" : "R6 control kept", ctrl_word, exp_ctrl);
    chk("R10 apply count", apply_cnt, a0 + int'(commit));
    chk("R2 disabled", sdo_oe, 0);
    chk("R2 low when disabled", sdo, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4);
    chk("R1 reset ctrl", ctrl_word, 16'h2000);
    chk("R1 reset apply", ctrl_apply, 0);
    chk("R1 reset oe", sdo_oe, 0);
    chk("R1 reset sdo", sdo, 0);
    rst_n = 1;
    wait_n(4);
    chk("R1 ctrl after release", ctrl_word, 16'h2000);

    for (int k = 0; k < 7; k++)
      frame(VEC[k][47:32], VEC[k][31:0], int'(VEC[k][55:48]), 1'b0);

    // R8: status changes mid-frame
    frame(16'hC3A5, 32'h0000_7E81, 16, 1'b1);

    // R9: clock and data toggling while deselected
    begin
      int a0;
      a0 = apply_cnt;
      for (int i = 0; i < 20; i++) begin
        sck = 1; sdi = i[0]; wait_n(H);
        chk("R9 oe stays low", sdo_oe, 0);
        sck = 0; wait_n(H);
      end
      chk("R9 ctrl unchanged", ctrl_word, exp_ctrl);
      chk("R9 no apply", apply_cnt, a0);
    end

    // R6 then R5 again: short read of bit0 followed by full frame
    frame(16'h0001, 32'h0, 0, 1'b0);
    frame(16'h8001, 32'h0000_2000, 16, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule